// File: doc/BRIEF.md
# Masked Interrupt Pending Controller

This block collects up to eight hardware interrupt sources into a byte-wide pending register and presents a single level interrupt to an upstream controller. A source sets its pending bit with a one-cycle raise pulse. Software clears a pending bit by writing its index to the acknowledge port. Hardware can also clear bits with a clear pulse. Software writes the mask register in inverted sense: a written 1 disables a source and a written 0 enables it.

The interrupt output is registered. After every mask write, raise, clear or acknowledge it shows whether any enabled bit is pending. A status read returns the pending byte on a 64-bit read bus, zero-extended, so a narrow reader and a wide reader see the same value.

A second mask register, for a companion controller that is not wired to raise interrupts, accepts writes and keeps the value. That value never affects the interrupt. The companion's status reads as zero and its acknowledges do nothing.

Top module: `irq_pend_ctrl`

## Requirements
- R1: While `rst` is high, and one cycle after it falls, the pending register, the enable vector, `irq_o` and `aux_mask_o` are all zero.
- R2: A write with `wr_addr` = 0 sets the enable vector to the bitwise complement of `wr_data`.
- R3: `irq_o` is registered. One cycle after any write or pulse it is high exactly when (pending AND enable) is nonzero.
- R4: Each bit set in `raise_i` for one cycle sets the matching pending bit.
- R5: Each bit set in `clear_i` for one cycle clears the matching pending bit.
- R6: A write with `wr_addr` = 1 clears pending bit number `wr_data[3:0]`. It leaves the other bits alone. Indices 8 to 15 clear nothing, and `wr_data[7:4]` is ignored.
- R7: When a raise and a clear, or a raise and an acknowledge, hit the same bit in the same cycle, the bit ends up set.
- R8: A read with `rd_sel` = 0 loads the pending register into `rd_data[7:0]` one cycle after `rd_en`. `rd_data[63:8]` is zero.
- R9: A write with `wr_addr` = 2 stores `wr_data` on `aux_mask_o`. It changes neither the enable vector nor `irq_o`.
- R10: A read with `rd_sel` = 1 returns zero on all of `rd_data`. A write with `wr_addr` = 3 leaves the pending register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_i | input | 8 | One-cycle pulses that set pending bits |
| clear_i | input | 8 | One-cycle pulses that clear pending bits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 primary mask, 1 primary acknowledge, 2 companion mask, 3 companion acknowledge |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Status read strobe |
| rd_sel | input | 1 | 0 primary status, 1 companion status |
| rd_data | output | 64 | Registered, zero-extended status |
| irq_o | output | 1 | Level interrupt to the upstream controller |
| aux_mask_o | output | 8 | Stored companion mask |

## Verification
The assertions check several behaviours on every cycle:
- `irq_o` tracks the registered pending and enable state.
- Raised bits land in the pending register.
- A mask write installs its complement.
- Acknowledge indices outside the byte leave the pending register untouched.
- The companion status reads zero and its mask is captured.

Some behaviours only the bench scenarios show:
- The interrupt output across all 256 mask values against a fixed pending pattern.
- Each of the 16 acknowledge indices, including the eight that must do nothing.
- The raise-beats-clear collision.
- That companion writes never disturb the primary interrupt.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  typedef enum logic [1:0] {
    WA_PRI_MASK = 2'd0,
    WA_PRI_ACK  = 2'd1,
    WA_SEC_MASK = 2'd2,
    WA_SEC_ACK  = 2'd3
  } wr_addr_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int W     = 8,
  parameter int IDX_W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raise_i,
  input  logic [W-1:0] clear_i,
  input  logic         mask_we,
  input  logic         ack_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0]     pend_q, en_q, pend_nxt, en_nxt, ack_clr;
  logic             irq_q;
  logic [IDX_W-1:0] ack_idx;

  assign ack_idx = wdata[IDX_W-1:0];

  always_comb begin
    ack_clr = '0;
    for (int i = 0; i < W; i++) begin
      if (ack_we && (ack_idx == IDX_W'(i))) ack_clr[i] = 1'b1;
    end
    pend_nxt = (pend_q & ~(clear_i | ack_clr)) | raise_i;
    en_nxt   = mask_we ? ~wdata : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      en_q   <= en_nxt;
      irq_q  <= |(pend_nxt & en_nxt);
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && en_q == '0 && !irq_q));
  // R3
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(pend_q & en_q));
  // R4
  raise_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|raise_i) |=> ((pend_q & $past(raise_i)) == $past(raise_i)));
  // R2
  mask_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (en_q == ~$past(wdata)));
  // R6
  ack_out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_we && int'(ack_idx) >= W && clear_i == '0)
      |=> (pend_q == ($past(pend_q) | $past(raise_i))));
endmodule

// File: rtl/irq_pend_rdport.sv
module irq_pend_rdport #(
  parameter int W    = 8,
  parameter int RD_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic            rd_sel,
  input  logic [W-1:0]    pend,
  output logic [RD_W-1:0] rd_data
);
  localparam int PAD_W = RD_W - W;
  logic [RD_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (rd_en) rd_q <= rd_sel ? '0 : {{PAD_W{1'b0}}, pend};
  end

  assign rd_data = rd_q;

  // R10
  sec_status_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel) |=> (rd_q == '0));
  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_q[RD_W-1:W] == '0);
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int W     = 8,
  parameter int IDX_W = 4,
  parameter int RD_W  = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    raise_i,
  input  logic [W-1:0]    clear_i,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic            rd_en,
  input  logic            rd_sel,
  output logic [RD_W-1:0] rd_data,
  output logic            irq_o,
  output logic [W-1:0]    aux_mask_o
);
  import irq_pend_pkg::*;

  wr_addr_e     waddr;
  logic         mask_we, ack_we, aux_we;
  logic [W-1:0] pend, en;
  logic [W-1:0] aux_q;

  assign waddr   = wr_addr_e'(wr_addr);
  assign mask_we = wr_en && (waddr == WA_PRI_MASK);
  assign ack_we  = wr_en && (waddr == WA_PRI_ACK);
  assign aux_we  = wr_en && (waddr == WA_SEC_MASK);

  irq_pend_bank #(.W(W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .raise_i(raise_i), .clear_i(clear_i),
    .mask_we(mask_we), .ack_we(ack_we), .wdata(wr_data),
    .pend_o(pend), .en_o(en), .irq_o(irq_o)
  );

  irq_pend_rdport #(.W(W), .RD_W(RD_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel),
    .pend(pend), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) aux_q <= '0;
    else if (aux_we) aux_q <= wr_data;
  end

  assign aux_mask_o = aux_q;

  // R9
  aux_capture_chk: assert property (@(posedge clk) disable iff (rst)
    aux_we |=> (aux_mask_o == $past(wr_data)));
  // R9
  aux_no_enable_chk: assert property (@(posedge clk) disable iff (rst)
    aux_we |=> $stable(en));
endmodule

// File: tb/irq_pend_ctrl_tb.sv
module irq_pend_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  raise_i = '0, clear_i = '0, wr_data = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [63:0] rd_data;
  logic        irq_o;
  logic [7:0]  aux_mask_o;

  int checks = 0, errors = 0;
  logic [7:0] m_pend = '0, m_en = '0, m_aux = '0;

  always #4 clk = ~clk;

  irq_pend_ctrl u_dut (
    .clk(clk), .rst(rst), .raise_i(raise_i), .clear_i(clear_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_o(irq_o), .aux_mask_o(aux_mask_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    case (a)
      2'd0: m_en = ~d;
      2'd1: if (d[3:0] < 4'd8) m_pend[d[2:0]] = 1'b0;
      2'd2: m_aux = d;
      default: ;
    endcase
  endtask

  task automatic pulse(input logic [7:0] r, input logic [7:0] c);
    @(negedge clk); raise_i = r; clear_i = c;
    @(negedge clk); raise_i = '0; clear_i = '0;
    m_pend = (m_pend & ~c) | r;
  endtask

  task automatic rd(input logic s, output logic [63:0] v);
    @(negedge clk); rd_en = 1'b1; rd_sel = s;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    check("R1 irq", {63'd0, irq_o}, 64'd0);
    check("R1 aux", {56'd0, aux_mask_o}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    rd(1'b0, v); check("R1 pend", v, 64'd0);
    pulse(8'hFF, 8'h00);
    check("R1 enables zero", {63'd0, irq_o}, 64'd0);

    // R2 R3: full sweep of mask values against pattern A5
    pulse(8'h00, 8'h5A);
    for (int m = 0; m < 256; m++) begin
      wr(2'd0, 8'(m));
      check("R2 R3 mask sweep", {63'd0, irq_o}, {63'd0, |(m_pend & m_en)});
    end
    rd(1'b0, v); check("R8 pend read", v, {56'd0, m_pend});

    // R4 R5 with all enabled
    wr(2'd0, 8'h00);
    pulse(8'h00, 8'hFF);
    check("R5 clear all irq", {63'd0, irq_o}, 64'd0);
    for (int b = 0; b < 8; b++) begin
      pulse(8'(1 << b), 8'h00);
      check("R4 raise irq", {63'd0, irq_o}, 64'd1);
      rd(1'b0, v); check("R4 raise pend", v, {56'd0, m_pend});
      pulse(8'h00, 8'(1 << b));
      check("R5 clear irq", {63'd0, irq_o}, 64'd0);
    end

    // R6: all 16 acknowledge indices, upper nibble set
    for (int i = 0; i < 16; i++) begin
      pulse(8'hFF, 8'h00);
      wr(2'd1, 8'(8'hB0 | i));
      rd(1'b0, v); check("R6 ack index", v, {56'd0, m_pend});
      check("R6 irq", {63'd0, irq_o}, {63'd0, |(m_pend & m_en)});
    end
    // R6: ack of the last enabled pending bit drops irq
    pulse(8'h00, 8'hFF);
    wr(2'd0, 8'hF7);
    pulse(8'h08, 8'h00);
    check("R6 irq before ack", {63'd0, irq_o}, 64'd1);
    wr(2'd1, 8'h03);
    check("R6 irq after ack", {63'd0, irq_o}, 64'd0);

    // R7: raise beats clear on the same bit
    wr(2'd0, 8'h00);
    pulse(8'h00, 8'hFF);
    @(negedge clk); raise_i = 8'h10; clear_i = 8'h10;
    @(negedge clk); raise_i = '0; clear_i = '0; m_pend = 8'h10;
    rd(1'b0, v); check("R7 raise over clear", v, 64'h10);
    check("R7 irq", {63'd0, irq_o}, 64'd1);
    // R7: raise beats acknowledge on the same bit
    @(negedge clk); raise_i = 8'h04; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h02;
    @(negedge clk); raise_i = '0; wr_en = 1'b0; m_pend = 8'h14;
    rd(1'b0, v); check("R7 raise over ack", v, 64'h14);

    // R9: companion mask stored, no effect on irq
    wr(2'd2, 8'hFF);
    check("R9 aux stored", {56'd0, aux_mask_o}, {56'd0, m_aux});
    check("R9 irq unchanged", {63'd0, irq_o}, 64'd1);
    wr(2'd2, 8'h3C);
    check("R9 aux stored 2", {56'd0, aux_mask_o}, 64'h3C);

    // R10: companion status zero, companion ack ignored
    rd(1'b1, v); check("R10 sec status", v, 64'd0);
    wr(2'd3, 8'h04);
    rd(1'b0, v); check("R10 sec ack ignored", v, {56'd0, m_pend});
    check("R10 irq", {63'd0, irq_o}, 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule